// File: doc/BRIEF.md
# PIO Command Flow Sequencer

This block is the per-port control core that walks a host adapter through one non-queued programmed-I/O command. The command can target a plain ATA or a packet (ATAPI) device, and it can move data in either direction. Software issues the command with three inputs: the direction, the packet flag and the requested block count. The sequencer then requests the command frame. It reacts to decoded frames from the device: PIO Setup, Data, and device-to-host Register with its interrupt bit. It emits single-cycle requests that the frame and DMA logic around it carry out.

A packet command spends its first PIO Setup on sending the packet command bytes, and only the second PIO Setup opens the data phase. A byte counter is loaded from the transfer count of the PIO Setup that opens the data phase. Writes cut this count into outgoing Data frames of at most `FRAME_MAX` bytes. Reads check every incoming Data frame against the counter. A Register frame closes the command, raises an interrupt request if its interrupt bit is set, and may ask for a link power-down state.

Top module: `pio_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `err` and every request pulse are 0.
- R2: `cmd_start` in idle gives exactly one `send_cmd` pulse, in the cycle after the start. The command is instead rejected into the error state, with no `send_cmd`, in any of these cases: the block count is 0, the block count is above `MAX_BLOCKS` (16), or the count is above 1 while `cap_multi` is 0.
- R3: For a packet command (`cmd_atapi`=1), the first PIO Setup frame (`rx_type`=0) produces exactly one `send_pkt` pulse. Only the following PIO Setup frame opens the data phase. A non-packet command never pulses `send_pkt`.
- R4: For a write, the PIO Setup transfer count `rx_count` is split into back-to-back `send_data` pulses. Each pulse carries `tx_len` = min(remaining, `FRAME_MAX`=8192), and the lengths sum to the count.
- R5: For a read, each Data frame (`rx_type`=1) with a length from 1 to min(remaining, 8192) gives one `recv_data` pulse and reduces the remaining count. A longer frame sends the block to the error state.
- R6: Once the data count reaches zero, a Register frame (`rx_type`=2) gives one `cmd_done` pulse and returns the block to idle. `irq_req` pulses with it only if `rx_irq`=1.
- R7: At completion, if `pm_aggr`=1 and `last_cmd`=1, the block pulses `pm_slumber` when `pm_slumber_sel`=1 and `pm_partial` when it is 0. Otherwise it pulses neither.
- R8: A frame that is not expected in the current state, including any frame in idle, sets `err`. `err` stays set, and `cmd_start` is ignored, until `err_clr` returns the block to idle.
- R9: A PIO Setup frame that opens the data phase with a transfer count of 0 sends the block to the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Issue a command (accepted in idle) |
| cmd_write | input | 1 | 1 = data to device, 0 = data to memory |
| cmd_atapi | input | 1 | 1 = packet command |
| cmd_blocks | input | BW | Number of data blocks requested |
| cap_multi | input | 1 | 1 = multi-block PIO supported |
| pm_aggr | input | 1 | Aggressive link power management enabled |
| pm_slumber_sel | input | 1 | 1 = Slumber, 0 = Partial |
| last_cmd | input | 1 | No other command outstanding |
| rx_valid | input | 1 | Decoded incoming frame present this cycle |
| rx_type | input | 2 | 0 PIO Setup, 1 Data, 2 Register, 3 other |
| rx_irq | input | 1 | Interrupt bit of a Register frame |
| rx_count | input | CW | PIO Setup transfer count or Data frame length, in bytes |
| err_clr | input | 1 | Leave the error state |
| send_cmd | output | 1 | Request to send the command frame |
| send_pkt | output | 1 | Request to send the packet command bytes |
| send_data | output | 1 | Request to send one Data frame |
| tx_len | output | CW | Byte length of the requested Data frame |
| recv_data | output | 1 | Request to store one received Data frame |
| cmd_done | output | 1 | Command completed |
| irq_req | output | 1 | Interrupt request |
| pm_partial | output | 1 | Request the Partial link state |
| pm_slumber | output | 1 | Request the Slumber link state |
| busy | output | 1 | Not idle |
| err | output | 1 | Protocol error is held |

## Verification
The bench uses the default parameters: a 16-bit count, frames of at most 8192 bytes and at most 16 blocks. With these values, transfer counts such as 20000 and 16385 produce three-frame data phases whose last frame is short. A count of 8192 and a read frame of 8193 sit exactly on either side of the frame limit. Block counts of 2 and 17 exercise the multi-block capability check and the block ceiling.

// File: rtl/pio_seq.sv
module pio_seq #(
  parameter int CW         = 16,
  parameter int BW         = 5,
  parameter int FRAME_MAX  = 8192,
  parameter int MAX_BLOCKS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic          cmd_atapi,
  input  logic [BW-1:0] cmd_blocks,
  input  logic          cap_multi,
  input  logic          pm_aggr,
  input  logic          pm_slumber_sel,
  input  logic          last_cmd,
  input  logic          rx_valid,
  input  logic [1:0]    rx_type,
  input  logic          rx_irq,
  input  logic [CW-1:0] rx_count,
  input  logic          err_clr,
  output logic          send_cmd,
  output logic          send_pkt,
  output logic          send_data,
  output logic [CW-1:0] tx_len,
  output logic          recv_data,
  output logic          cmd_done,
  output logic          irq_req,
  output logic          pm_partial,
  output logic          pm_slumber,
  output logic          busy,
  output logic          err
);

  localparam logic [CW-1:0] FMAX = CW'(FRAME_MAX);
  localparam logic [1:0] T_SETUP = 2'd0, T_DATA = 2'd1, T_REG = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WSETUP, S_PKT, S_TX, S_RX, S_WREG, S_ERR
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic w_q, a_q, pkt_q;

  logic [CW-1:0] chunk;
  logic blk_bad, rx_ok;

  assign chunk   = (cnt > FMAX) ? FMAX : cnt;
  assign blk_bad = (cmd_blocks == '0) || (int'(cmd_blocks) > MAX_BLOCKS) ||
                   (!cap_multi && cmd_blocks > BW'(1));
  assign rx_ok   = (rx_type == T_DATA) && (rx_count != '0) &&
                   (rx_count <= FMAX) && (rx_count <= cnt);

  assign send_cmd  = (st == S_CMD);
  assign send_pkt  = (st == S_PKT);
  assign send_data = (st == S_TX);
  assign tx_len    = send_data ? chunk : '0;
  assign busy      = (st != S_IDLE);
  assign err       = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      w_q        <= 1'b0;
      a_q        <= 1'b0;
      pkt_q      <= 1'b0;
      recv_data  <= 1'b0;
      cmd_done   <= 1'b0;
      irq_req    <= 1'b0;
      pm_partial <= 1'b0;
      pm_slumber <= 1'b0;
    end else begin
      recv_data  <= 1'b0;
      cmd_done   <= 1'b0;
      irq_req    <= 1'b0;
      pm_partial <= 1'b0;
      pm_slumber <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rx_valid) st <= S_ERR;
          else if (cmd_start) begin
            w_q   <= cmd_write;
            a_q   <= cmd_atapi;
            pkt_q <= 1'b0;
            st    <= blk_bad ? S_ERR : S_CMD;
          end
        end
        S_CMD: st <= rx_valid ? S_ERR : S_WSETUP;
        S_WSETUP: begin
          if (rx_valid) begin
            if (rx_type != T_SETUP) st <= S_ERR;
            else if (a_q && !pkt_q) st <= S_PKT;
            else if (rx_count == '0) st <= S_ERR;
            else begin
              cnt <= rx_count;
              st  <= w_q ? S_TX : S_RX;
            end
          end
        end
        S_PKT: begin
          pkt_q <= 1'b1;
          st    <= rx_valid ? S_ERR : S_WSETUP;
        end
        S_TX: begin
          if (rx_valid) st <= S_ERR;
          else begin
            cnt <= cnt - chunk;
            if (cnt == chunk) st <= S_WREG;
          end
        end
        S_RX: begin
          if (rx_valid) begin
            if (rx_ok) begin
              recv_data <= 1'b1;
              cnt       <= cnt - rx_count;
              if (rx_count == cnt) st <= S_WREG;
            end else st <= S_ERR;
          end
        end
        S_WREG: begin
          if (rx_valid) begin
            if (rx_type == T_REG) begin
              cmd_done   <= 1'b1;
              irq_req    <= rx_irq;
              pm_slumber <= pm_aggr && last_cmd && pm_slumber_sel;
              pm_partial <= pm_aggr && last_cmd && !pm_slumber_sel;
              st         <= S_IDLE;
            end else st <= S_ERR;
          end
        end
        S_ERR: if (err_clr) st <= S_IDLE;
        default: st <= S_ERR;
      endcase
    end
  end

endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int CW        = 16,
  parameter int FRAME_MAX = 8192
) (
  input logic          clk,
  input logic          rst_n,
  input logic          send_cmd,
  input logic          send_pkt,
  input logic          send_data,
  input logic [CW-1:0] tx_len,
  input logic          cmd_done,
  input logic          irq_req,
  input logic          pm_partial,
  input logic          pm_slumber,
  input logic          err,
  input logic          err_clr
);

  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_cmd, send_pkt, send_data}));

  a_r2_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    send_cmd |=> !send_cmd);

  a_r3_pkt_single: assert property (@(posedge clk) disable iff (!rst_n)
    send_pkt |=> !send_pkt);

  a_r4_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    send_data |-> (tx_len != '0 && int'(tx_len) <= FRAME_MAX));

  a_r6_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cmd_done);

  a_r7_pm_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_partial || pm_slumber) |-> (cmd_done && $onehot0({pm_partial, pm_slumber})));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

endmodule

bind pio_seq pio_seq_chk #(.CW(CW), .FRAME_MAX(FRAME_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .send_cmd(send_cmd), .send_pkt(send_pkt),
  .send_data(send_data), .tx_len(tx_len), .cmd_done(cmd_done),
  .irq_req(irq_req), .pm_partial(pm_partial), .pm_slumber(pm_slumber),
  .err(err), .err_clr(err_clr)
);

// File: tb/sim_pio_seq.sv
module sim_pio_seq;
  localparam int CW = 16, BW = 5, FMAX = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_write = 0, cmd_atapi = 0, cap_multi = 1;
  logic [BW-1:0] cmd_blocks = 1;
  logic pm_aggr = 0, pm_slumber_sel = 0, last_cmd = 0;
  logic rx_valid = 0, rx_irq = 0, err_clr = 0;
  logic [1:0] rx_type = 0;
  logic [CW-1:0] rx_count = 0;
  logic send_cmd, send_pkt, send_data, recv_data, cmd_done, irq_req;
  logic pm_partial, pm_slumber, busy, err;
  logic [CW-1:0] tx_len;

  pio_seq u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int n_cmd, n_pkt, n_data, n_bytes, n_recv, n_done, n_irq, n_part, n_slp;

  always @(posedge clk) begin
    n_cmd   += int'(send_cmd);
    n_pkt   += int'(send_pkt);
    n_data  += int'(send_data);
    n_bytes += send_data ? int'(tx_len) : 0;
    n_recv  += int'(recv_data);
    n_done  += int'(cmd_done);
    n_irq   += int'(irq_req);
    n_part  += int'(pm_partial);
    n_slp   += int'(pm_slumber);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_cmd = 0; n_pkt = 0; n_data = 0; n_bytes = 0; n_recv = 0;
    n_done = 0; n_irq = 0; n_part = 0; n_slp = 0;
  endtask

  task automatic frame(input logic [1:0] t, input int c, input logic irq);
    rx_valid = 1; rx_type = t; rx_count = CW'(c); rx_irq = irq;
    @(negedge clk);
    rx_valid = 0; rx_irq = 0; rx_count = 0;
  endtask

  task automatic start(input logic w, input logic a, input int blk);
    @(negedge clk);
    clr_counts();
    cmd_write = w; cmd_atapi = a; cmd_blocks = BW'(blk); cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    @(negedge clk);
  endtask

  task automatic run(input logic w, input logic a, input int cnt, input logic irq);
    int rem;
    start(w, a, 1);
    if (a) begin
      frame(2'd0, 0, 0);
      @(negedge clk);
    end
    frame(2'd0, cnt, 0);
    if (w) repeat ((cnt + FMAX - 1) / FMAX + 1) @(negedge clk);
    else begin
      rem = cnt;
      while (rem > 0) begin
        frame(2'd1, (rem > FMAX) ? FMAX : rem, 0);
        rem -= (rem > FMAX) ? FMAX : rem;
      end
    end
    frame(2'd2, 0, irq);
    repeat (2) @(negedge clk);
  endtask

  task automatic recover();
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    @(negedge clk);
  endtask

  // {write, atapi, count[15:0], irq, frames[3:0]}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd512,   1'b1, 4'd1},
    {1'b1, 1'b0, 16'd20000, 1'b0, 4'd3},
    {1'b0, 1'b0, 16'd8192,  1'b1, 4'd1},
    {1'b0, 1'b0, 16'd16385, 1'b0, 4'd3},
    {1'b1, 1'b1, 16'd2048,  1'b1, 4'd1},
    {1'b0, 1'b1, 16'd8193,  1'b0, 4'd2}
  };

  initial begin
    #(8ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clr_counts();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 pulses", int'(send_cmd | send_pkt | send_data | recv_data | cmd_done | irq_req), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic w, a, irq;
      int cnt, fr;
      {w, a, cnt[15:0], irq, fr[3:0]} = VEC[i];
      cnt = int'(VEC[i][20:5]); fr = int'(VEC[i][3:0]);
      run(w, a, cnt, irq);
      check("R2 one send_cmd", n_cmd, 1);
      check("R3 send_pkt count", n_pkt, a ? 1 : 0);
      check("R4 write frames", n_data, w ? fr : 0);
      check("R4 write bytes", n_bytes, w ? cnt : 0);
      check("R5 read frames", n_recv, w ? 0 : fr);
      check("R6 done", n_done, 1);
      check("R6 irq", n_irq, int'(irq));
      check("R6 idle after", int'(busy | err), 0);
      check("R7 no pm", n_part + n_slp, 0);
    end

    // R7 power requests
    pm_aggr = 1; last_cmd = 1; pm_slumber_sel = 1;
    run(1, 0, 100, 0);
    check("R7 slumber", n_slp, 1);
    check("R7 partial off", n_part, 0);
    pm_slumber_sel = 0;
    run(0, 0, 100, 1);
    check("R7 partial", n_part, 1);
    check("R7 slumber off", n_slp, 0);
    last_cmd = 0;
    run(1, 0, 100, 0);
    check("R7 not last", n_part + n_slp, 0);
    pm_aggr = 0;

    // R2 block checks
    cap_multi = 0;
    start(1, 0, 2);
    check("R2 multi without cap err", int'(err), 1);
    check("R2 multi without cap no cmd", n_cmd, 0);
    recover();
    cap_multi = 1;
    start(1, 0, 17);
    check("R2 over max err", int'(err), 1);
    recover();
    start(1, 0, 0);
    check("R2 zero blocks err", int'(err), 1);
    recover();
    start(0, 0, 2);
    check("R2 two blocks ok", int'(err), 0);
    check("R2 two blocks cmd", n_cmd, 1);
    frame(2'd0, 1024, 0);
    frame(2'd1, 512, 0);
    frame(2'd1, 512, 0);
    frame(2'd2, 0, 0);
    @(negedge clk);
    check("R5 two read frames", n_recv, 2);
    check("R6 two block done", n_done, 1);

    // R9 zero count
    start(1, 0, 1);
    frame(2'd0, 0, 0);
    check("R9 zero count err", int'(err), 1);
    recover();

    // R5 oversized and overlong read frames
    start(0, 0, 1);
    frame(2'd0, 20000, 0);
    frame(2'd1, 8193, 0);
    check("R5 oversize err", int'(err), 1);
    check("R5 oversize no recv", n_recv, 0);
    recover();
    start(0, 0, 1);
    frame(2'd0, 100, 0);
    frame(2'd1, 101, 0);
    check("R5 beyond count err", int'(err), 1);
    recover();

    // R8 unexpected frames and sticky error
    frame(2'd1, 4, 0);
    check("R8 frame in idle err", int'(err), 1);
    clr_counts();
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    repeat (2) @(negedge clk);
    check("R8 start ignored", n_cmd, 0);
    check("R8 err held", int'(err), 1);
    recover();
    check("R8 cleared", int'(busy | err), 0);
    start(1, 0, 1);
    frame(2'd1, 4, 0);
    check("R8 data before setup err", int'(err), 1);
    recover();
    start(1, 0, 1);
    frame(2'd0, 10, 0);
    frame(2'd2, 0, 0);
    check("R8 register during send err", int'(err), 1);
    check("R8 no done", n_done, 0);
    recover();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule